// File: doc/BRIEF.md
# Thirty-Two Pin GPIO Bank with Blink and Grouped Interrupts

This block is one bank of 32 general purpose pins, programmed through a plain word-wide register port (address, write strobe, write data, registered read data). Each pin can drive a stored output value or act as an input. A driven pin can be set to flash from a shared free-running timer. Each input can be inverted before anything else sees it. The bank sends four interrupt lines to the system interrupt controller, one for each group of eight neighbouring pins. A design that needs more pins places more banks.

Pin inputs pass through a two-stage synchroniser. After that, an optional per-pin inversion is applied. The result is what software reads back and what the interrupt logic watches. Interrupt detection always looks for a rising edge or a high level. A falling-edge or active-low source is handled by setting that pin's inversion bit. Edge enables and level enables sit in two separate mask words. A pending cause bit drives its group's line only while one of its two masks is set.

Top module: `gpio_bank`

## Requirements
- R1: After synchronous reset, all registers are zero except the direction register, which is all ones. `pin_oe`, `pin_out` and `irq` are zero.
- R2: Direction register bit = 1 makes the pin an input (`pin_oe` bit low, `pin_out` bit low). Bit = 0 makes the pin drive its data-out bit on `pin_out`, with `pin_oe` bit high. Both outputs are registered.
- R3: When a driven pin has its blink bit set and its data-out bit is 1, `pin_out` follows the top bit of a free-running BLINK_W-bit counter. It is high for half of every 2^BLINK_W cycles. When the data-out bit is 0, the pin stays low.
- R4: The input word (offset 0x10, read-only) returns the two-flop-synchronised `pin_in` XOR the polarity register (offset 0x0C).
- R5: A rising edge of a pin's adjusted input sets its cause bit, whatever the masks hold. With the polarity bit set, a falling edge of the raw pin sets it.
- R6: While a pin's level mask bit (offset 0x1C) is set and its adjusted input is high, its cause bit is set again every cycle. A clear therefore does not stick while the level persists.
- R7: Writing the cause register (offset 0x14) clears each bit written 0 and leaves each bit written 1 unchanged. Writing all zeros clears every pending cause.
- R8: If a new event and a clearing write hit the same cause bit in the same cycle, the bit stays set.
- R9: `irq[g]` is the registered OR over pins 8g..8g+7 of cause AND (edge mask OR level mask). The edge mask is at offset 0x18. A pending cause with both masks clear raises nothing.
- R10: Register offsets are: data out 0x00, direction 0x04, blink 0x08, polarity 0x0C, input 0x10, cause 0x14, edge mask 0x18, level mask 0x1C. `rd_data` is valid one cycle after `addr`. Offsets at 0x20 or above, or with addr[1:0] nonzero, read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe for the current cycle |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data for the previous cycle's address |
| pin_in | input | DATA_W | Raw pin levels from the pads |
| pin_out | output | DATA_W | Output level for each pin |
| pin_oe | output | DATA_W | Drive enable for each pin, high means drive |
| irq | output | DATA_W/GROUP_W | One active-high interrupt per eight-pin group |

## Verification
The hardest case to reach is a clearing write to the cause register that lands in the exact cycle an edge reaches the detector. The edge only arrives there after the two synchroniser stages. The bench changes the pin on a falling clock edge and counts two rising edges. It then puts the write on the bus so that it is sampled together with the edge. A second cause bit is left pending beforehand, so the readback shows both that the write took effect and that the new event survived it. Blink duty is checked with a narrowed counter. The bench counts high samples over two full periods.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int REG_SPAN_BITS = 5;

  typedef enum logic [2:0] {
    SEL_DOUT  = 3'd0,
    SEL_DIR   = 3'd1,
    SEL_BLINK = 3'd2,
    SEL_POL   = 3'd3,
    SEL_DIN   = 3'd4,
    SEL_CAUSE = 3'd5,
    SEL_EMASK = 3'd6,
    SEL_LMASK = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_in_cond.sv
module gpio_in_cond #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] invert,
  output logic [W-1:0] level,
  output logic [W-1:0] rise
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
      prev_q <= level;
    end
  end

  assign level = sync_q ^ invert;
  assign rise  = level & ~prev_q;
endmodule

// File: rtl/gpio_blink_timer.sv
module gpio_blink_timer #(
  parameter int BW = 24
) (
  input  logic clk,
  input  logic rst,
  output logic phase
);
  logic [BW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign phase = cnt_q[BW-1];
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int W = 32,
  parameter int G = 8,
  localparam int NG = W / G
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  pending,
  input  logic [W-1:0]  enable,
  output logic [NG-1:0] line
);
  logic [W-1:0] live;
  assign live = pending & enable;

  for (genvar g = 0; g < NG; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) line[g] <= 1'b0;
      else     line[g] <= |live[g*G +: G];
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int GROUP_W = 8,
  parameter int ADDR_W  = 6,
  parameter int BLINK_W = 24,
  localparam int NGRP   = DATA_W / GROUP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe,
  output logic [NGRP-1:0]   irq
);
  logic [DATA_W-1:0] dout_q, dir_q, blink_q, pol_q, cause_q, emask_q, lmask_q;
  logic [DATA_W-1:0] din, rise, set_vec;
  logic              phase;
  logic              mapped, wr_hit;
  reg_sel_e          sel;

  assign mapped = (addr[ADDR_W-1:REG_SPAN_BITS] == '0) && (addr[1:0] == 2'b00);
  assign sel    = reg_sel_e'(addr[REG_SPAN_BITS-1:2]);
  assign wr_hit = wr_en && mapped;

  gpio_in_cond #(.W(DATA_W)) u_in (
    .clk(clk), .rst(rst), .raw(pin_in), .invert(pol_q),
    .level(din), .rise(rise)
  );

  gpio_blink_timer #(.BW(BLINK_W)) u_blink (
    .clk(clk), .rst(rst), .phase(phase)
  );

  assign set_vec = rise | (lmask_q & din);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q  <= '0;
      dir_q   <= '1;
      blink_q <= '0;
      pol_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else if (wr_hit) begin
      case (sel)
        SEL_DOUT:  dout_q  <= wr_data;
        SEL_DIR:   dir_q   <= wr_data;
        SEL_BLINK: blink_q <= wr_data;
        SEL_POL:   pol_q   <= wr_data;
        SEL_EMASK: emask_q <= wr_data;
        SEL_LMASK: lmask_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                            cause_q <= '0;
    else if (wr_hit && sel == SEL_CAUSE) cause_q <= (cause_q & wr_data) | set_vec;
    else                                cause_q <= cause_q | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
    end else begin
      pin_out <= ((dout_q & ~blink_q) | (dout_q & blink_q & {DATA_W{phase}})) & ~dir_q;
      pin_oe  <= ~dir_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (!mapped) rd_data <= '0;
    else begin
      case (sel)
        SEL_DOUT:  rd_data <= dout_q;
        SEL_DIR:   rd_data <= dir_q;
        SEL_BLINK: rd_data <= blink_q;
        SEL_POL:   rd_data <= pol_q;
        SEL_DIN:   rd_data <= din;
        SEL_CAUSE: rd_data <= cause_q;
        SEL_EMASK: rd_data <= emask_q;
        default:   rd_data <= lmask_q;
      endcase
    end
  end

  gpio_irq_merge #(.W(DATA_W), .G(GROUP_W)) u_irq (
    .clk(clk), .rst(rst), .pending(cause_q), .enable(emask_q | lmask_q),
    .line(irq)
  );
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker #(
  parameter int W  = 32,
  parameter int G  = 8,
  parameter int AW = 6,
  localparam int NG = W / G
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [W-1:0]  wr_data,
  input logic [W-1:0]  rd_data,
  input logic [W-1:0]  pin_oe,
  input logic [NG-1:0] irq,
  input logic [W-1:0]  cause,
  input logic [W-1:0]  emask,
  input logic [W-1:0]  lmask,
  input logic [W-1:0]  set_vec
);
  assert_inputs_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pin_oe == '0);

  assert_clear_all_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == AW'(8'h14) && wr_data == '0 && set_vec == '0) |=> cause == '0);

  assert_event_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((cause & $past(set_vec)) == $past(set_vec)));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (addr[AW-1:5] != '0) |=> rd_data == '0);

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assert_irq_source_R9: assert property (@(posedge clk) disable iff (rst)
      irq[g] |-> $past(|(cause[g*G +: G] & (emask[g*G +: G] | lmask[g*G +: G]))));
  end
endmodule

bind gpio_bank gpio_bank_checker #(.W(DATA_W), .G(GROUP_W), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rd_data(rd_data), .pin_oe(pin_oe), .irq(irq), .cause(cause_q),
  .emask(emask_q), .lmask(lmask_q), .set_vec(set_vec)
);

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int BW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] pin_in = '0;
  logic [DW-1:0] pin_out, pin_oe;
  logic [3:0]    irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  gpio_bank #(.DATA_W(DW), .GROUP_W(8), .ADDR_W(AW), .BLINK_W(BW)) uut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  localparam logic [AW-1:0] A_DOUT = 6'h00, A_DIR = 6'h04, A_BLINK = 6'h08,
    A_POL = 6'h0C, A_DIN = 6'h10, A_CAUSE = 6'h14, A_EMASK = 6'h18, A_LMASK = 6'h1C;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    rd_reg(A_DIR, v);   check("R1 dir", v, 32'hFFFF_FFFF);
    rd_reg(A_DOUT, v);  check("R1 dout", v, 32'h0);
    rd_reg(A_CAUSE, v); check("R1 cause", v, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 irq", {28'h0, irq}, 32'h0);
  endtask

  task automatic t_direction();
    logic [DW-1:0] v;
    wr_reg(A_DOUT, 32'hA5A5_0F0F);
    wr_reg(A_DIR, 32'hFFFF_0000);
    idle(2);
    check("R2 pin_oe", pin_oe, 32'h0000_FFFF);
    check("R2 pin_out", pin_out, 32'h0000_0F0F);
    rd_reg(A_DOUT, v); check("R10 dout readback", v, 32'hA5A5_0F0F);
    wr_reg(A_DIR, 32'h0);
    idle(2);
    check("R2 all driven", pin_out, 32'hA5A5_0F0F);
  endtask

  task automatic t_blink();
    int hi0 = 0, hi1 = 0;
    wr_reg(A_DOUT, 32'h3);
    wr_reg(A_BLINK, 32'h1);
    idle(2);
    for (int i = 0; i < 32; i++) begin
      hi0 += pin_out[0];
      hi1 += pin_out[1];
      @(negedge clk);
    end
    check("R3 blink duty", hi0, 16);
    check("R3 steady pin", hi1, 32);
    wr_reg(A_DOUT, 32'h2);
    idle(2);
    hi0 = 0;
    for (int i = 0; i < 32; i++) begin
      hi0 += pin_out[0];
      @(negedge clk);
    end
    check("R3 blink with zero", hi0, 0);
    wr_reg(A_BLINK, 32'h0);
    wr_reg(A_DOUT, 32'h0);
    wr_reg(A_DIR, 32'hFFFF_FFFF);
  endtask

  task automatic t_polarity();
    logic [DW-1:0] v;
    pin_in = 32'h0000_00F0;
    wr_reg(A_POL, 32'h0000_0030);
    idle(4);
    rd_reg(A_DIN, v); check("R4 din", v, 32'h0000_00C0);
    wr_reg(A_DIN, 32'hFFFF_FFFF);
    rd_reg(A_DIN, v); check("R4 din read-only", v, 32'h0000_00C0);
    pin_in = 32'h0;
    wr_reg(A_POL, 32'h0);
    idle(4);
    wr_reg(A_CAUSE, 32'h0);
    rd_reg(A_CAUSE, v); check("R7 cleared", v, 32'h0);
  endtask

  task automatic t_edge();
    logic [DW-1:0] v;
    wr_reg(A_EMASK, 32'h0000_0002);
    pin_in[1] = 1'b1;
    idle(6);
    rd_reg(A_CAUSE, v); check("R5 rising cause", v, 32'h0000_0002);
    check("R9 irq grp0", {28'h0, irq}, 32'h1);
    wr_reg(A_CAUSE, 32'h0);
    pin_in[9] = 1'b1;
    idle(5);
    wr_reg(A_POL, 32'h0000_0200);
    idle(5);
    wr_reg(A_CAUSE, 32'h0);
    wr_reg(A_EMASK, 32'h0000_0202);
    idle(2);
    check("R9 irq idle", {28'h0, irq}, 32'h0);
    pin_in[9] = 1'b0;
    idle(6);
    rd_reg(A_CAUSE, v); check("R5 falling cause", v, 32'h0000_0200);
    check("R9 irq grp1", {28'h0, irq}, 32'h2);
    wr_reg(A_CAUSE, 32'h0);
    wr_reg(A_EMASK, 32'h0);
    idle(3);
    check("R9 irq cleared", {28'h0, irq}, 32'h0);
  endtask

  task automatic t_clear();
    logic [DW-1:0] v;
    pin_in[17:16] = 2'b11;
    idle(6);
    rd_reg(A_CAUSE, v); check("R5 two edges", v, 32'h0003_0000);
    wr_reg(A_CAUSE, 32'hFFFE_FFFF);
    rd_reg(A_CAUSE, v); check("R7 selective clear", v, 32'h0002_0000);
    wr_reg(A_CAUSE, 32'h0);
    rd_reg(A_CAUSE, v); check("R7 clear all", v, 32'h0);
  endtask

  task automatic t_level();
    logic [DW-1:0] v;
    wr_reg(A_LMASK, 32'h0100_0000);
    pin_in[24] = 1'b1;
    idle(6);
    check("R9 level irq", {28'h0, irq}, 32'h8);
    wr_reg(A_CAUSE, 32'h0);
    rd_reg(A_CAUSE, v); check("R6 level persists", v, 32'h0100_0000);
    pin_in[24] = 1'b0;
    idle(4);
    wr_reg(A_CAUSE, 32'h0);
    idle(2);
    rd_reg(A_CAUSE, v); check("R6 level gone", v, 32'h0);
    check("R9 level irq off", {28'h0, irq}, 32'h0);
    wr_reg(A_POL, 32'h0200_0200);
    wr_reg(A_LMASK, 32'h0200_0000);
    idle(4);
    wr_reg(A_CAUSE, 32'h0);
    rd_reg(A_CAUSE, v); check("R6 active low level", v, 32'h0200_0000);
    pin_in[25] = 1'b1;
    idle(4);
    wr_reg(A_CAUSE, 32'h0);
    idle(1);
    rd_reg(A_CAUSE, v); check("R6 active low released", v, 32'h0);
    wr_reg(A_LMASK, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [DW-1:0] v;
    pin_in[3] = 1'b1;
    idle(6);
    rd_reg(A_CAUSE, v); check("R5 pre-pending", v, 32'h0000_0008);
    pin_in[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    addr = A_CAUSE; wr_data = 32'h0; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    rd_reg(A_CAUSE, v); check("R8 event beats clear", v, 32'h0000_0004);
    wr_reg(A_CAUSE, 32'h0);
  endtask

  task automatic t_mask();
    logic [DW-1:0] v;
    pin_in[12] = 1'b1;
    idle(6);
    rd_reg(A_CAUSE, v); check("R5 unmasked cause", v, 32'h0000_1000);
    check("R9 masked no irq", {28'h0, irq}, 32'h0);
    wr_reg(A_EMASK, 32'h0000_1000);
    idle(2);
    check("R9 late enable", {28'h0, irq}, 32'h2);
    wr_reg(A_EMASK, 32'h0);
    wr_reg(A_CAUSE, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [DW-1:0] v;
    wr_reg(A_DOUT, 32'h1234_5678);
    wr_reg(6'h20, 32'hDEAD_BEEF);
    rd_reg(6'h20, v); check("R10 unmapped 0x20", v, 32'h0);
    rd_reg(6'h3C, v); check("R10 unmapped 0x3C", v, 32'h0);
    wr_reg(6'h01, 32'hFFFF_FFFF);
    rd_reg(6'h01, v); check("R10 misaligned", v, 32'h0);
    rd_reg(A_DOUT, v); check("R10 dout untouched", v, 32'h1234_5678);
    wr_reg(A_BLINK, 32'h00FF_0000);
    rd_reg(A_BLINK, v); check("R10 blink readback", v, 32'h00FF_0000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_direction();
    t_blink();
    t_polarity();
    t_edge();
    t_clear();
    t_level();
    t_set_wins();
    t_mask();
    t_unmapped();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule